// File: doc/BRIEF.md
# Parallel I/O Port with Edge Capture

This block is a small bus-attached general-purpose I/O port for up to 32 pins. Software reaches four word registers over a simple read/write bus. Through them it sets which pins are driven, sets the values those pins drive, and reads back the pin levels. It can also enable interrupts for each pin and read and clear the latched pin events.

Input pins pass through a two-stage synchronizer. A third stage holds each pin's level from one clock earlier, and pin events are found by comparing the two. A parameter fixed at build time selects the event type: rising edge, falling edge, either edge, or level high. In the edge types a detected event sets a sticky capture bit, and software clears that bit by writing a one to it. In level-high mode the interrupt follows the masked pin levels directly, and the capture register stays empty. One combined interrupt line leaves the block. The pad tristate buffers are outside the block and use the output-value and output-enable vectors.

Top module: `pio_edge_ctrl`

## Requirements
- R1: After reset, pin_oe, pin_out and irq are all zero, and reads at offsets 0x0, 0x4, 0x8 and 0xC all return zero.
- R2: A write at offset 0x4 (direction) sets pin_oe on the following cycle, where bit i equal to 1 makes pin i an output. A write at offset 0x0 sets pin_out to the written low PIN_COUNT bits.
- R3: A read at offset 0x0 returns the pin_in levels after a two-flop synchronizer, with bit i belonging to pin i.
- R4: With TRIGGER set to rising, a 0-to-1 change on a synchronized pin sets its bit in the capture register at offset 0xC, three clocks after the pin changes. The bit then stays set after the pin returns low.
- R5: With TRIGGER set to falling, only 1-to-0 changes set capture bits.
- R6: With TRIGGER set to both, either direction of change sets the capture bit.
- R7: With TRIGGER set to level, irq is high while any bit of (synchronized pins AND mask) is 1, and it drops when the pin falls without any register write. The capture register reads zero in this mode.
- R8: Capture bits are set whatever the mask at offset 0x8 holds. irq stays low while the mask is zero, and a mask bit of 1 lets that pin's captured event raise irq.
- R9: Writing offset 0xC clears exactly the capture bits written as 1. Bits written as 0 keep their value.
- R10: If a new event and a clearing write to the same capture bit fall in the same cycle, the bit stays set.
- R11: Register bits at or above PIN_COUNT read as zero and ignore writes.
- R12: Read data appears on bus_rdata the cycle after bus_rd is sampled and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, registered |
| pin_in | input | PIN_COUNT | Asynchronous pin levels |
| pin_out | output | PIN_COUNT | Value to drive on each pin |
| pin_oe | output | PIN_COUNT | Output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong synchronizer or previous-value stage moves the edge-capture time away from the third clock after a pin change, or captures the wrong polarity. This shows in the capture value read back right after that window. A wrong clear priority shows in the next capture read after a write that lands on the event cycle: the bit reads clear where it should stay set. A mask or mode error shows on irq in the same cycle the capture bit or the pin level changes, so the bench checks irq immediately after each pin or mask change.

// File: rtl/gpio_edge_pkg.sv
// Shared constants and the event-type enumeration for the parallel I/O port.
package gpio_edge_pkg;
    // Event type chosen at build time.
    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_mode_e;

    // Byte offsets of the four word registers.
    localparam int OFF_DATA = 'h0;
    localparam int OFF_DIR  = 'h4;
    localparam int OFF_MASK = 'h8;
    localparam int OFF_CAP  = 'hC;
endpackage

// File: rtl/gpio_in_sync.sv
// Two-flop synchronizer plus a one-cycle-delayed copy per pin.
// Assumes pin_async may change at any time relative to clk.
module gpio_in_sync #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_async,
    output logic [W-1:0] sync_q,
    output logic [W-1:0] prev_q
);
    logic [W-1:0] meta_q;

    // Move the pins into the clock domain and keep the last synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end
endmodule

// File: rtl/gpio_event_detect.sv
// Combinational event finder. The build-time TRIGGER picks which change of
// a synchronized pin counts as an event. Level mode produces no events
// because its interrupt comes from the pin level itself.
module gpio_event_detect
    import gpio_edge_pkg::*;
#(
    parameter int         W       = 24,
    parameter trig_mode_e TRIGGER = TRIG_RISE
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    output logic [W-1:0] evt
);
    generate
        if (TRIGGER == TRIG_RISE) begin : g_rise
            assign evt = cur & ~prev;
        end else if (TRIGGER == TRIG_FALL) begin : g_fall
            assign evt = ~cur & prev;
        end else if (TRIGGER == TRIG_BOTH) begin : g_both
            assign evt = cur ^ prev;
        end else begin : g_level
            logic unused_level;
            assign unused_level = ^{cur, prev};
            assign evt = '0;
        end
    endgenerate
endmodule

// File: rtl/gpio_capture_reg.sv
// Sticky event bits with write-one-to-clear. An event in the same cycle as
// a clear of that bit keeps the bit set.
module gpio_capture_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] cap_q
);
    logic [W-1:0] clr_vec;

    // Select the bits the current write asks to clear.
    always_comb clr_vec = clr_en ? clr_bits : '0;

    // Clear first, then OR the new events so that events win.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= (cap_q & ~clr_vec) | evt;
    end
endmodule

// File: rtl/pio_edge_ctrl.sv
// Parallel I/O port: output value, output enable, interrupt mask and event
// capture registers on a simple word bus with one cycle of read latency.
// Assumes PIN_COUNT <= BUS_W <= 32, word-aligned offsets, and a bus master
// that never asserts bus_wr and bus_rd together.
module pio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int         PIN_COUNT = 24,
    parameter trig_mode_e TRIGGER   = TRIG_RISE,
    parameter int         BUS_W     = 32,
    parameter int         ADDR_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic                 irq
);
    localparam logic [BUS_W-1:0] PIN_MASK = BUS_W'((64'd1 << PIN_COUNT) - 64'd1);

    logic [PIN_COUNT-1:0] sync_q, prev_q, evt;
    logic [PIN_COUNT-1:0] data_q;
    logic [BUS_W-1:0]     dir_q, mask_q, cap_q;
    logic [BUS_W-1:0]     sync_wide, evt_wide, wdata_pins;
    logic                 sel_data, sel_dir, sel_mask, sel_cap;

    // Decode the full offset so that other addresses have no effect.
    always_comb begin
        sel_data = (bus_addr == ADDR_W'(OFF_DATA));
        sel_dir  = (bus_addr == ADDR_W'(OFF_DIR));
        sel_mask = (bus_addr == ADDR_W'(OFF_MASK));
        sel_cap  = (bus_addr == ADDR_W'(OFF_CAP));
    end

    assign wdata_pins = bus_wdata & PIN_MASK;
    assign sync_wide  = BUS_W'(sync_q);
    assign evt_wide   = BUS_W'(evt);

    gpio_in_sync #(.W(PIN_COUNT)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_in),
        .sync_q    (sync_q),
        .prev_q    (prev_q)
    );

    gpio_event_detect #(.W(PIN_COUNT), .TRIGGER(TRIGGER)) i_detect (
        .cur  (sync_q),
        .prev (prev_q),
        .evt  (evt)
    );

    gpio_capture_reg #(.W(BUS_W)) i_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_wide),
        .clr_en   (bus_wr && sel_cap),
        .clr_bits (wdata_pins),
        .cap_q    (cap_q)
    );

    // Software-written control registers; bits above PIN_COUNT stay zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else if (bus_wr) begin
            if (sel_data) data_q <= bus_wdata[PIN_COUNT-1:0];
            if (sel_dir)  dir_q  <= wdata_pins;
            if (sel_mask) mask_q <= wdata_pins;
        end
    end

    // Registered read port; the value holds until the next read.
    always_ff @(posedge clk) begin
        if (!rst_n)         bus_rdata <= '0;
        else if (bus_rd) begin
            if (sel_data)      bus_rdata <= sync_wide;
            else if (sel_dir)  bus_rdata <= dir_q;
            else if (sel_mask) bus_rdata <= mask_q;
            else if (sel_cap)  bus_rdata <= cap_q;
            else               bus_rdata <= '0;
        end
    end

    assign pin_out = data_q;
    assign pin_oe  = dir_q[PIN_COUNT-1:0];

    // Interrupt source: masked pin level in level mode, masked capture otherwise.
    generate
        if (TRIGGER == TRIG_LEVEL) begin : g_irq_level
            assign irq = |(sync_wide & mask_q);
        end else begin : g_irq_edge
            assign irq = |(cap_q & mask_q);
        end
    endgenerate
endmodule

// File: rtl/pio_edge_ctrl_chk.sv
// Property checker for pio_edge_ctrl, attached to every instance by bind.
// Assumes the synchronous active-low reset of the checked block.
module pio_edge_ctrl_chk
    import gpio_edge_pkg::*;
#(
    parameter int PIN_COUNT = 24,
    parameter int BUS_W     = 32,
    parameter int ADDR_W    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [BUS_W-1:0]     bus_wdata,
    input logic [BUS_W-1:0]     bus_rdata,
    input logic [PIN_COUNT-1:0] pin_out,
    input logic [PIN_COUNT-1:0] pin_oe,
    input logic                 irq,
    input logic [BUS_W-1:0]     mask_q,
    input logic [BUS_W-1:0]     cap_q
);
    localparam logic [BUS_W-1:0] PIN_MASK = BUS_W'((64'd1 << PIN_COUNT) - 64'd1);

    // R2: a direction write reaches pin_oe one cycle later
    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_DIR)) |=> (pin_oe == $past(bus_wdata[PIN_COUNT-1:0])));

    // R2: a data write reaches pin_out one cycle later
    assert_data_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_DATA)) |=> (pin_out == $past(bus_wdata[PIN_COUNT-1:0])));

    // R9: capture bits only fall on a write to the capture offset
    assert_cap_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(OFF_CAP)) |=> (($past(cap_q) & ~cap_q) == '0));

    // R8: a zero mask keeps the interrupt low
    assert_mask_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    // R12: read data holds when no read was requested
    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R11: no read returns a bit above the pin count
    assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd) |-> ((bus_rdata & ~PIN_MASK) == '0));
endmodule

bind pio_edge_ctrl pio_edge_ctrl_chk #(
    .PIN_COUNT (PIN_COUNT),
    .BUS_W     (BUS_W),
    .ADDR_W    (ADDR_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .mask_q    (mask_q),
    .cap_q     (cap_q)
);

// File: tb/test_pio_edge_ctrl.sv
// Directed bench: four copies of the port, one per event type, share the
// bus and pins so each scenario checks every mode at once.
module test_pio_edge_ctrl;
    import gpio_edge_pkg::*;

    localparam int PINS = 24;
    localparam int MAX_CYCLES = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [PINS-1:0] pin_in = '0;
    logic [31:0] rd_r, rd_f, rd_b, rd_l;
    logic [PINS-1:0] out_r, out_f, out_b, out_l;
    logic [PINS-1:0] oe_r, oe_f, oe_b, oe_l;
    logic irq_r, irq_f, irq_b, irq_l;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pio_edge_ctrl #(.PIN_COUNT(PINS), .TRIGGER(TRIG_RISE)) i_pio_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_r), .pin_in(pin_in), .pin_out(out_r),
        .pin_oe(oe_r), .irq(irq_r));
    pio_edge_ctrl #(.PIN_COUNT(PINS), .TRIGGER(TRIG_FALL)) i_pio_edge_ctrl_fall (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_f), .pin_in(pin_in), .pin_out(out_f),
        .pin_oe(oe_f), .irq(irq_f));
    pio_edge_ctrl #(.PIN_COUNT(PINS), .TRIGGER(TRIG_BOTH)) i_pio_edge_ctrl_both (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_b), .pin_in(pin_in), .pin_out(out_b),
        .pin_oe(oe_b), .irq(irq_b));
    pio_edge_ctrl #(.PIN_COUNT(PINS), .TRIGGER(TRIG_LEVEL)) i_pio_edge_ctrl_level (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_l), .pin_in(pin_in), .pin_out(out_l),
        .pin_oe(oe_l), .irq(irq_l));

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Change the pins and wait until a capture can have happened.
    task automatic set_pins(input logic [PINS-1:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1", "pin_oe", 32'(oe_r), 32'h0);
        check("R1", "pin_out", 32'(out_r), 32'h0);
        check("R1", "irq any", {28'h0, irq_r, irq_f, irq_b, irq_l}, 32'h0);
        bus_read(4'h0); check("R1", "data", rd_r, 32'h0);
        bus_read(4'h4); check("R1", "dir", rd_r, 32'h0);
        bus_read(4'h8); check("R1", "mask", rd_r, 32'h0);
        bus_read(4'hC); check("R1", "cap", rd_r, 32'h0);
    endtask

    task automatic t_outputs;
        bus_write(4'h4, 32'hFFFF_FFFF);
        check("R2", "oe all", 32'(oe_r), 32'h00FF_FFFF);
        bus_read(4'h4); check("R11", "dir upper", rd_r, 32'h00FF_FFFF);
        bus_write(4'h0, 32'hFFA5_A5A5);
        check("R2", "pin_out", 32'(out_r), 32'h00A5_A5A5);
        bus_write(4'h4, 32'h0000_00FF);
        bus_read(4'h4); check("R2", "dir readback", rd_r, 32'h0000_00FF);
        bus_write(4'h4, 32'h0000_0F0F);
        check("R12", "rdata held", rd_r, 32'h0000_00FF);
        check("R2", "oe new", 32'(oe_r), 32'h0000_0F0F);
    endtask

    task automatic t_capture_rise;
        set_pins(24'h123456);
        bus_read(4'h0); check("R3", "pin data", rd_r, 32'h0012_3456);
        bus_read(4'hC);
        check("R4", "rise cap", rd_r, 32'h0012_3456);
        check("R5", "fall cap", rd_f, 32'h0);
        check("R6", "both cap", rd_b, 32'h0012_3456);
        check("R7", "level cap", rd_l, 32'h0);
        check("R8", "irq masked", {31'h0, irq_r}, 32'h0);
    endtask

    task automatic t_mask;
        bus_write(4'h8, 32'hFF00_0004);
        bus_read(4'h8); check("R11", "mask upper", rd_r, 32'h0000_0004);
        check("R8", "irq rise", {31'h0, irq_r}, 32'h1);
        check("R8", "irq both", {31'h0, irq_b}, 32'h1);
        check("R5", "irq fall", {31'h0, irq_f}, 32'h0);
        check("R7", "irq level", {31'h0, irq_l}, 32'h1);
    endtask

    task automatic t_clear;
        bus_write(4'hC, 32'h0000_0010);
        bus_read(4'hC);
        check("R9", "partial clear rise", rd_r, 32'h0012_3446);
        check("R9", "partial clear both", rd_b, 32'h0012_3446);
        bus_write(4'hC, 32'hFFFF_FFFF);
        bus_read(4'hC);
        check("R9", "full clear rise", rd_r, 32'h0);
        check("R9", "full clear both", rd_b, 32'h0);
        check("R9", "irq after clear", {31'h0, irq_r}, 32'h0);
        check("R7", "level irq stays", {31'h0, irq_l}, 32'h1);
    endtask

    task automatic t_fall;
        set_pins(24'h000000);
        check("R7", "level irq drops", {31'h0, irq_l}, 32'h0);
        check("R5", "irq fall", {31'h0, irq_f}, 32'h1);
        bus_read(4'hC);
        check("R5", "fall cap", rd_f, 32'h0012_3456);
        check("R4", "rise no fall", rd_r, 32'h0);
        check("R6", "both fall", rd_b, 32'h0012_3456);
    endtask

    task automatic t_race;
        bus_write(4'hC, 32'hFFFF_FFFF);
        set_pins(24'h000001);
        set_pins(24'h000000);
        bus_read(4'hC);
        check("R4", "rise held low", rd_r, 32'h1);
        check("R5", "fall bit0", rd_f, 32'h1);
        @(negedge clk);
        pin_in = 24'h000001;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'hC; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_read(4'hC);
        check("R10", "rise wins", rd_r, 32'h1);
        check("R10", "both wins", rd_b, 32'h1);
        check("R9", "fall cleared", rd_f, 32'h0);
    endtask

    task automatic t_level;
        bus_write(4'h8, 32'h0000_0001);
        check("R7", "level pin high", {31'h0, irq_l}, 32'h1);
        set_pins(24'h000000);
        check("R7", "level pin low", {31'h0, irq_l}, 32'h0);
        check("R4", "rise latched irq", {31'h0, irq_r}, 32'h1);
        bus_read(4'h0); check("R3", "pins low", rd_r, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_outputs();
        t_capture_rise();
        t_mask();
        t_clear();
        t_fall();
        t_race();
        t_level();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule